// File: doc/BRIEF.md
# PHY Management Frame Master

This block issues read and write transactions to one PHY over a two-wire management interface: a clock line (`mdc`) and a bidirectional data line. The data line is presented as a data output (`mdo`), an output enable (`mdo_en`) and an input (`mdi`), to be combined into a tristate pad outside the block. A host raises `req_valid` for one cycle with the operation, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. The block then clocks out the whole frame with no further host action. It raises `done` for one cycle when the frame is over. For a read, the value is then on `rd_data`.

The management clock is derived from the system clock. `div_half` sets the length of each clock phase in system clocks and is latched when a request is accepted. Every bit time is a low phase followed by a high phase. The block changes the line only while the clock is low. It samples the input at the end of the high phase, after a two-flop synchroniser.

The frame sequencer walks through named states. IDLE moves to PREAMBLE on an accepted request. PREAMBLE moves to START after 32 bits, and START moves to OPCODE after 2 bits. OPCODE moves to PHYADDR after 2 bits, PHYADDR to REGADDR after 5, and REGADDR to TURN after 5. TURN moves to DATA after 2 bits for a write or 1 bit for a read. DATA moves to TRAIL after 16 bits, and TRAIL returns to IDLE after 1 bit, pulsing `done` on the way.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 bit times, bit indices 0 to 31, in which `mdo_en`=1 and `mdo`=1.
- R2: Bits 32 and 33 drive the start code 0 then 1. Bits 34 and 35 drive the opcode: 1 then 0 for a read (`req_write`=0), 0 then 1 for a write (`req_write`=1). `mdo_en`=1 throughout.
- R3: Bits 36 to 40 drive `req_phy` and bits 41 to 45 drive `req_reg`, each MSB first with `mdo_en`=1.
- R4: A write has 65 bit times. Bits 46 and 47 are released (`mdo_en`=0, `mdo`=0). Bits 48 to 63 drive `req_wdata` MSB first with `mdo_en`=1.
- R5: A read has 64 bit times. `mdo_en`=0 and `mdo`=0 from bit 46 on. The input is sampled in bits 47 to 62, MSB first, and `rd_data` holds that value from the `done` cycle on.
- R6: The last bit time of every frame is released (`mdo_en`=0). While `busy`=0, `mdc`, `mdo` and `mdo_en` are all 0.
- R7: `mdo` and `mdo_en` change only on the edge that ends a high phase, so they are stable while `mdc` is high.
- R8: Each `mdc` phase lasts max(`div_half`, 2) system clocks, using the value latched at acceptance.
- R9: `busy` is 1 from the cycle after acceptance until the frame ends. A `req_valid` while busy is ignored: the frame in progress is unchanged and no second frame follows.
- R10: `done` is a one-cycle pulse, N·2·H+1 cycles after the accepting edge, where N is the bit count and H the phase length. `busy` falls in the same cycle.
- R11: After reset, `busy`, `done`, `mdc`, `mdo`, `mdo_en` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | Management clock phase length in system clocks (minimum 2) |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output value |
| mdo_en | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input |

## Verification
A frame of N bits with phase length H lasts N·2·H cycles from the accepting edge, so the bench expects `done` exactly N·2·H+1 cycles after it and checks that it clears one cycle later. Line values are compared at every rising `mdc` against a bit index that advances on each falling `mdc`. The modelled PHY updates `mdi` one half-cycle after each falling edge, which leaves at least 2·H−1 system clocks for the synchroniser before the sample point. All observations are made on falling system-clock edges, midway between the registered changes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS  = 32;
    localparam int ADDR_BITS = 5;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURN,
        ST_DATA,
        ST_TRAIL
    } mdio_state_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             mdc,
    output logic             bit_end
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic             hi_q;
    logic             phase_end;

    assign phase_end = run && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= MIN_HALF;
            cnt_q  <= '0;
            hi_q   <= 1'b0;
        end else begin
            if (load)
                half_q <= (div_in < MIN_HALF) ? MIN_HALF : div_in;
            if (!run) begin
                cnt_q <= '0;
                hi_q  <= 1'b0;
            end else if (phase_end) begin
                cnt_q <= '0;
                hi_q  <= ~hi_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign mdc     = hi_q;
    assign bit_end = phase_end && hi_q;
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_phy,
    input  logic [ADDR_BITS-1:0] req_reg,
    input  logic [DATA_BITS-1:0] req_wdata,
    input  logic                 bit_end,
    input  logic                 mdi_s,
    output logic                 accept,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 mdo,
    output logic                 mdo_en
);
    mdio_state_e              state_q, state_d;
    logic [CNT_W-1:0]         bcnt_q;
    logic [CNT_W-1:0]         last_idx;
    logic                     wr_q;
    logic [2*ADDR_BITS-1:0]   hdr_q;
    logic [DATA_BITS-1:0]     sh_q;
    logic [DATA_BITS-1:0]     rd_q;
    logic                     done_q;
    logic                     step_last;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // index of the final bit time of the current state
    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: last_idx = CNT_W'(PRE_BITS - 1);
            ST_START:    last_idx = CNT_W'(1);
            ST_OPCODE:   last_idx = CNT_W'(1);
            ST_PHYADDR:  last_idx = CNT_W'(ADDR_BITS - 1);
            ST_REGADDR:  last_idx = CNT_W'(ADDR_BITS - 1);
            ST_TURN:     last_idx = wr_q ? CNT_W'(1) : CNT_W'(0);
            ST_DATA:     last_idx = CNT_W'(DATA_BITS - 1);
            default:     last_idx = '0;
        endcase
    end

    assign step_last = bit_end && (bcnt_q == last_idx);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (step_last) state_d = ST_START;
            ST_START:    if (step_last) state_d = ST_OPCODE;
            ST_OPCODE:   if (step_last) state_d = ST_PHYADDR;
            ST_PHYADDR:  if (step_last) state_d = ST_REGADDR;
            ST_REGADDR:  if (step_last) state_d = ST_TURN;
            ST_TURN:     if (step_last) state_d = ST_DATA;
            ST_DATA:     if (step_last) state_d = ST_TRAIL;
            ST_TRAIL:    if (step_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register with the frame shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            wr_q    <= 1'b0;
            hdr_q   <= '0;
            sh_q    <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_TRAIL) && step_last;
            if (accept) begin
                bcnt_q <= '0;
                wr_q   <= req_write;
                hdr_q  <= {req_phy, req_reg};
                sh_q   <= req_wdata;
            end else if (bit_end) begin
                bcnt_q <= step_last ? '0 : bcnt_q + 1'b1;
                if (state_q == ST_PHYADDR || state_q == ST_REGADDR)
                    hdr_q <= hdr_q << 1;
                if (state_q == ST_DATA)
                    sh_q <= wr_q ? (sh_q << 1) : {sh_q[DATA_BITS-2:0], mdi_s};
                if (state_q == ST_TRAIL && !wr_q)
                    rd_q <= sh_q;
            end
        end
    end

    // line outputs decoded from the registered state
    always_comb begin
        mdo    = 1'b0;
        mdo_en = 1'b0;
        unique case (state_q)
            ST_PREAMBLE: begin mdo_en = 1'b1; mdo = 1'b1;                  end
            ST_START:    begin mdo_en = 1'b1; mdo = bcnt_q[0];             end
            ST_OPCODE:   begin mdo_en = 1'b1; mdo = bcnt_q[0] ^ ~wr_q;     end
            ST_PHYADDR,
            ST_REGADDR:  begin mdo_en = 1'b1; mdo = hdr_q[2*ADDR_BITS-1];  end
            ST_DATA:     begin mdo_en = wr_q; mdo = wr_q & sh_q[DATA_BITS-1]; end
            default:     begin mdo_en = 1'b0; mdo = 1'b0;                  end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div_half,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_phy,
    input  logic [ADDR_BITS-1:0] req_reg,
    input  logic [DATA_BITS-1:0] req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 mdc,
    output logic                 mdo,
    output logic                 mdo_en,
    input  logic                 mdi
);
    logic accept;
    logic bit_end;
    logic mdi_s;

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .div_in  (div_half),
        .run     (busy),
        .mdc     (mdc),
        .bit_end (bit_end)
    );

    mdio_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mdi),
        .dout  (mdi_s)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .bit_end   (bit_end),
        .mdi_s     (mdi_s),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdo       (mdo),
        .mdo_en    (mdo_en)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdo,
    input logic mdo_en
);
    AST_LINE_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdo) && $stable(mdo_en))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo && !mdo_en)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10

    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .mdc    (mdc),
    .mdo    (mdo),
    .mdo_en (mdo_en)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_half = '0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [4:0]       req_phy = '0;
    logic [4:0]       req_reg = '0;
    logic [15:0]      req_wdata = '0;
    logic             busy, done, mdc, mdo, mdo_en;
    logic [15:0]      rd_data;
    logic             mdi = 1'b1;

    int checks = 0;
    int fails  = 0;
    int gcyc   = 0;

    always #10 clk = ~clk;

    mdio_master #(.DIV_W(DIV_W)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .div_half(div_half),
        .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected {oe, data} for bit index i
    function automatic logic [1:0] exp_bit(input bit wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] wd,
                                           input int i);
        if (i < 32)  return 2'b11;
        if (i == 32) return 2'b10;
        if (i == 33) return 2'b11;
        if (i == 34) return wr ? 2'b10 : 2'b11;
        if (i == 35) return wr ? 2'b11 : 2'b10;
        if (i < 41)  return {1'b1, phy[4-(i-36)]};
        if (i < 46)  return {1'b1, rg[4-(i-41)]};
        if (wr && i >= 48 && i <= 63) return {1'b1, wd[15-(i-48)]};
        return 2'b00;
    endfunction

    // requirement group of bit index i
    function automatic int grp(input bit wr, input int i, input int n);
        if (i == n - 1) return 6;
        if (i < 32) return 1;
        if (i < 36) return 2;
        if (i < 46) return 3;
        return wr ? 4 : 5;
    endfunction

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] rdv,
                             input int div, input bit inject);
        int heff = (div < 2) ? 2 : div;
        int n    = wr ? 65 : 64;
        int cyc  = 0;
        int idx  = 0;
        int rises = 0;
        int last_t = 0;
        int herr = 0;
        int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0;
        bit prev = 1'b0;
        bit fin = 1'b0;
        logic [1:0] eb;
        @(negedge clk);
        div_half  = DIV_W'(div);
        req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
        mdi = 1'b1;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            req_valid = 1'b0;
            if (mdc && !prev) begin
                eb = exp_bit(wr, phy, rg, wd, idx);
                if ({mdo_en, mdo} != eb) begin
                    case (grp(wr, idx, n))
                        1: e1++; 2: e2++; 3: e3++; 4: e4++; 5: e5++; default: e6++;
                    endcase
                end
                rises++;
                if (last_t != 0 && cyc - last_t != heff) herr++;
                last_t = cyc;
            end
            if (!mdc && prev) begin
                if (cyc - last_t != heff) herr++;
                last_t = cyc;
                idx++;
                mdi = (!wr && idx >= 47 && idx <= 62) ? rdv[15-(idx-47)] : 1'b1;
            end
            prev = mdc;
            if (cyc == 5) chk(busy == 1'b1, "R9 busy mid-frame", int'(busy), 1);
            if (inject && cyc == 40) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg;
                req_wdata = ~wd;
            end
            if (done || cyc > 2000) fin = 1'b1;
        end
        chk(cyc == n * 2 * heff + 1, "R10 done timing", cyc, n * 2 * heff + 1);
        chk(busy == 1'b0, "R10 busy falls with done", int'(busy), 0);
        chk(rises == n, wr ? "R4 bit count" : "R5 bit count", rises, n);
        chk(herr == 0, "R8 phase length", herr, 0);
        chk(e1 == 0, "R1 preamble", e1, 0);
        chk(e2 == 0, "R2 start/opcode", e2, 0);
        chk(e3 == 0, "R3 address fields", e3, 0);
        if (wr) chk(e4 == 0, "R4 write turnaround/data", e4, 0);
        else    chk(e5 == 0, "R5 read release", e5, 0);
        chk(e6 == 0, "R6 trailing bit released", e6, 0);
        if (!wr) chk(rd_data == rdv, "R5 read data", int'(rd_data), int'(rdv));
        chk({mdc, mdo, mdo_en} == 3'b000, "R6 idle lines", int'({mdc, mdo, mdo_en}), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
        if (inject) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (busy || mdc) begin
                    chk(1'b0, "R9 ignored request started a frame", int'(busy), 0);
                    break;
                end
            end
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            gcyc++;
            if (gcyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        int divs[5] = '{0, 1, 2, 3, 5};
        logic [15:0] wd, rdv;
        repeat (3) @(negedge clk);
        chk({busy, done, mdc, mdo, mdo_en} == 5'b0, "R11 reset outputs",
            int'({busy, done, mdc, mdo, mdo_en}), 0);
        chk(rd_data == 16'h0, "R11 reset rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int d = 0; d < 5; d++) begin
            for (int k = 0; k < 4; k++) begin
                wd  = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 :
                      (k == 2) ? 16'hA5C3 : 16'h8001 ^ 16'(d * 16'h1357);
                rdv = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF :
                      (k == 2) ? 16'h3C5A : 16'h7FFE ^ 16'(d * 16'h0F0F);
                run_frame(1'b1, 5'(5'h1F ^ (k * 7)), 5'(k * 9 + d), wd, rdv, divs[d], k == 2);
                run_frame(1'b0, 5'(k * 11 + d), 5'(5'h15 ^ k), ~wd, rdv, divs[d], k == 3);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule